// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

The block takes two streams of 14-bit offset-binary converter samples and drives them onto output buses after a fixed pipeline delay. On the way it recodes every word into one of three number formats: straight offset binary, two's complement or Gray code. A test mode replaces both channels with the words of an on-chip pseudorandom sequence. The seed of that sequence can be forced by holding the generator in reset.

The block clock runs at four times the sample rate. Each sample period is four clock phases, numbered 0 to 3 from reset. The bus layout can be switched between two forms. In the first, each channel has its own bus for the whole period. In the second, both channels share bus A (channel A in phases 0–1, channel B in phases 2–3) and bus B is turned off. A data clock output marks where the data is valid, and its polarity can be inverted. Each channel has an active-low output enable that turns off its data and its data clock, and a power-down input turns off both channels.

Top module: `dual_sample_formatter`

## Requirements
- R1: After reset, both buses read zero, and they stay zero until the first captured sample has crossed the pipeline.
- R2: A sample pair present during sample period p is captured at the last clock of that period and is on the buses throughout period p+LAT (LAT=12). With code select 0 or 3 the word passes unchanged.
- R3: With code select 1 (two's complement), the output word is the offset-binary word with its MSB (bit 13) inverted.
- R4: With code select 2 (Gray), output bit i equals offset-binary bit i XOR bit i+1, and the MSB is unchanged.
- R5: With interleave off, bus A carries channel A and bus B carries channel B in all four phases of a period.
- R6: With interleave on, bus A carries channel A in phases 0–1 and channel B in phases 2–3, while bus B's enable is low and bus B and its data clock read 0.
- R7: The data clock of an enabled channel is high in phases 1 and 2 and low in phases 3 and 0, so it rises one clock after channel A settles and falls one clock after channel B settles. The polarity input inverts it.
- R8: A channel's drive enable is high only when its active-low enable input is 0 and power-down is 0. While the enable is low, that channel's bus and data clock read 0.
- R9: With test mode on, both channels carry the generator word instead of the input samples, recoded by the code select. The generator starts at seed 0x2AAA. It shifts left once per sample period in test mode, taking in feedback = XOR of bits 13, 12, 11 and 1. It holds its state when test mode is off.
- R10: While the generator hold input is high, the generator reloads the seed on every clock, so each period captured under hold carries the seed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, four clocks per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_a | input | 14 | Channel A offset-binary sample |
| smp_b | input | 14 | Channel B offset-binary sample |
| code_sel | input | 2 | Output code: 0 offset binary, 1 two's complement, 2 Gray, 3 offset binary |
| ilv_en | input | 1 | Interleave both channels on bus A |
| dco_inv | input | 1 | Invert the data clock outputs |
| tst_en | input | 1 | Replace samples with the pseudorandom word |
| pn_hold | input | 1 | Hold the generator at its seed |
| oe_n_a | input | 1 | Active-low output enable, channel A |
| oe_n_b | input | 1 | Active-low output enable, channel B |
| pwdn | input | 1 | Power-down, disables both channels |
| out_a | output | 14 | Bus A data |
| out_b | output | 14 | Bus B data |
| drv_a_en | output | 1 | Tri-state drive enable for bus A and its data clock |
| drv_b_en | output | 1 | Tri-state drive enable for bus B and its data clock |
| dco_a | output | 1 | Data clock for bus A |
| dco_b | output | 1 | Data clock for bus B |

## Verification
The assertions check the following on every cycle: the data clock edges fall only at their phase slots, the delay line holds still between captures, power-down and interleave keep their outputs disabled, and a held generator sits at its seed. Only the bench scenarios can show the end-to-end content: the twelve-period latency, the three recodings of every 14-bit value, the placement of channel B in the second half of an interleaved period, and the exact pseudorandom sequence across hold and pause periods.

// File: rtl/dfmt_pkg.sv
package dfmt_pkg;

   typedef enum logic [1:0] {
      CODE_OFFSET = 2'd0,
      CODE_TWOS   = 2'd1,
      CODE_GRAY   = 2'd2,
      CODE_SPARE  = 2'd3
   } code_e;

   localparam int NUM_CH = 2;

endpackage

// File: rtl/dfmt_code_conv.sv
module dfmt_code_conv
   import dfmt_pkg::*;
#(
   parameter int DW = 14
) (
   input  code_e         sel,
   input  logic [DW-1:0] ob,
   output logic [DW-1:0] cw
);

   logic [DW-1:0] twos_w;
   logic [DW-1:0] gray_w;

   if (DW < 2) begin : g_bad_dw
      $error("dfmt_code_conv: DW must be at least 2");
   end

   assign twos_w = {~ob[DW-1], ob[DW-2:0]};

   // R4: each bit folds in its upper neighbour; the top bit has none
   assign gray_w[DW-1] = ob[DW-1];
   for (genvar i = 0; i < DW - 1; i++) begin : g_gray
      assign gray_w[i] = ob[i] ^ ob[i+1];
   end

   always_comb begin
      unique case (sel)
         CODE_TWOS: cw = twos_w;
         CODE_GRAY: cw = gray_w;
         default:   cw = ob;
      endcase
   end

endmodule

// File: rtl/dfmt_pn_gen.sv
module dfmt_pn_gen #(
   parameter int          DW   = 14,
   parameter logic [DW-1:0] TAPS = 14'h3802,
   parameter logic [DW-1:0] SEED = 14'h2AAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          step,
   output logic [DW-1:0] word
);

   logic [DW-1:0] st;
   logic          fb;

   if (SEED == '0) begin : g_bad_seed
      $error("dfmt_pn_gen: SEED must be nonzero");
   end
   if (TAPS[DW-1] == 1'b0) begin : g_bad_taps
      $error("dfmt_pn_gen: top tap must be set for an invertible register");
   end

   assign fb = ^(st & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= SEED;
      else if (hold) st <= SEED;
      else if (step) st <= {st[DW-2:0], fb};
   end

   assign word = st;

   // R10
   pn_hold_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> word == SEED);

   // R9
   pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word != '0);

   // R9
   pn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !step) |=> $stable(word));

endmodule

// File: rtl/dfmt_delay_line.sv
module dfmt_delay_line #(
   parameter int W     = 14,
   parameter int DEPTH = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dfmt_delay_line: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (adv) q <= din;
      end
      assign dout = q;
   end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stg <= '0;
         else if (adv) stg <= {stg[DEPTH-2:0], din};
      end
      assign dout = stg[DEPTH-1];
   end

   // R2
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(dout));

endmodule

// File: rtl/dual_sample_formatter.sv
module dual_sample_formatter
   import dfmt_pkg::*;
#(
   parameter int            DW      = 14,
   parameter int            LAT     = 12,
   parameter logic [DW-1:0] PN_TAPS = 14'h3802,
   parameter logic [DW-1:0] PN_SEED = 14'h2AAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] smp_a,
   input  logic [DW-1:0] smp_b,
   input  logic [1:0]    code_sel,
   input  logic          ilv_en,
   input  logic          dco_inv,
   input  logic          tst_en,
   input  logic          pn_hold,
   input  logic          oe_n_a,
   input  logic          oe_n_b,
   input  logic          pwdn,
   output logic [DW-1:0] out_a,
   output logic [DW-1:0] out_b,
   output logic          drv_a_en,
   output logic          drv_b_en,
   output logic          dco_a,
   output logic          dco_b
);

   localparam int NPH  = 4;
   localparam int PH_W = $clog2(NPH);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPH - 1);

   if (LAT < 1) begin : g_bad_lat
      $error("dual_sample_formatter: LAT must be at least 1");
   end

   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] ph_nxt;
   logic            take;
   logic            dco_q;
   logic [DW-1:0]   pn_word;
   logic [DW-1:0]   raw   [NUM_CH];
   logic [DW-1:0]   coded [NUM_CH];
   logic [DW-1:0]   head  [NUM_CH];
   code_e           csel;

   // phase counter: four clocks per sample period
   assign ph_nxt = ph + PH_W'(1);
   assign take   = (ph == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= '0;
         dco_q <= 1'b0;
      end else begin
         ph    <= ph_nxt;
         dco_q <= (ph_nxt == PH_W'(1)) || (ph_nxt == PH_W'(2));
      end
   end

   dfmt_pn_gen #(
      .DW   (DW),
      .TAPS (PN_TAPS),
      .SEED (PN_SEED)
   ) u_pn (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (pn_hold),
      .step  (take & tst_en),
      .word  (pn_word)
   );

   assign csel   = code_e'(code_sel);
   assign raw[0] = tst_en ? pn_word : smp_a;
   assign raw[1] = tst_en ? pn_word : smp_b;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      dfmt_code_conv #(
         .DW (DW)
      ) u_conv (
         .sel (csel),
         .ob  (raw[ch]),
         .cw  (coded[ch])
      );

      dfmt_delay_line #(
         .W     (DW),
         .DEPTH (LAT)
      ) u_dly (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (take),
         .din   (coded[ch]),
         .dout  (head[ch])
      );
   end

   // output drive and bus layout
   assign drv_a_en = !oe_n_a && !pwdn;
   assign drv_b_en = !oe_n_b && !pwdn && !ilv_en;

   assign out_a = !drv_a_en ? '0 : ((ilv_en && ph[PH_W-1]) ? head[1] : head[0]);
   assign out_b = drv_b_en ? head[1] : '0;
   assign dco_a = drv_a_en & (dco_q ^ dco_inv);
   assign dco_b = drv_b_en & (dco_q ^ dco_inv);

   // R7
   dco_rise_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dco_q) |-> ph == PH_W'(1));

   // R7
   dco_fall_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dco_q) |-> ph == PH_LAST);

   // R8
   pwdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwdn |-> (!drv_a_en && !drv_b_en && !dco_a && !dco_b));

   // R6
   ilv_bus_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ilv_en |-> (out_b == '0 && !dco_b));

endmodule

// File: tb/tb_dual_sample_formatter.sv
module tb_dual_sample_formatter;

   localparam int DW   = 14;
   localparam int LAT  = 12;
   localparam int NP   = 20480;
   localparam logic [DW-1:0] SEED = 14'h2AAA;
   localparam logic [DW-1:0] TAPS = 14'h3802;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] smp_a = '0, smp_b = '0;
   logic [1:0]    code_sel = 2'd0;
   logic          ilv_en = 1'b0, dco_inv = 1'b0, tst_en = 1'b0, pn_hold = 1'b0;
   logic          oe_n_a = 1'b0, oe_n_b = 1'b0, pwdn = 1'b0;
   logic [DW-1:0] out_a, out_b;
   logic          drv_a_en, drv_b_en, dco_a, dco_b;

   int n_chk = 0;
   int n_err = 0;
   int p = 0;
   bit done = 1'b0;
   logic [DW-1:0] pn_s = SEED;
   logic [DW-1:0] ea [NP];
   logic [DW-1:0] eb [NP];
   int            etag [NP];

   always #10 clk = ~clk;

   dual_sample_formatter dut (
      .clk, .rst_n, .smp_a, .smp_b, .code_sel, .ilv_en, .dco_inv, .tst_en,
      .pn_hold, .oe_n_a, .oe_n_b, .pwdn, .out_a, .out_b, .drv_a_en,
      .drv_b_en, .dco_a, .dco_b
   );

   function automatic logic [DW-1:0] recode(input logic [DW-1:0] x, input logic [1:0] s);
      case (s)
         2'd1:    return x ^ 14'h2000;        // R3
         2'd2:    return x ^ (x >> 1);        // R4
         default: return x;                   // R2
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // one sample period: apply at phase-0 negedge, check all four phases
   task automatic period(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [1:0] cs,
                         input logic ilv, input logic inv, input logic tst, input logic hld,
                         input logic oena, input logic oenb, input logic pd);
      logic [DW-1:0] wa, wb, ha, hb;
      logic ena, enb, dv;
      int tg;
      string ta, tb;
      smp_a = a; smp_b = b; code_sel = cs; ilv_en = ilv; dco_inv = inv;
      tst_en = tst; pn_hold = hld; oe_n_a = oena; oe_n_b = oenb; pwdn = pd;
      if (tst) begin
         wa = hld ? SEED : pn_s;
         wb = wa;
      end else begin
         wa = a;
         wb = b;
      end
      if (hld) pn_s = SEED;
      else if (tst) pn_s = {pn_s[DW-2:0], ^(pn_s & TAPS)};
      ea[p] = recode(wa, cs);
      eb[p] = recode(wb, cs);
      etag[p] = tst ? (hld ? 10 : 9) : (cs == 2'd1 ? 3 : (cs == 2'd2 ? 4 : 2));
      if (p >= LAT) begin
         ha = ea[p-LAT]; hb = eb[p-LAT]; tg = etag[p-LAT];
      end else begin
         ha = '0; hb = '0; tg = 1;       // R1: pipeline still empty
      end
      ena = !oena && !pd;
      enb = !oenb && !pd && !ilv;        // R8, R6
      for (int k = 0; k < 4; k++) begin
         #2;
         dv = ((k == 1) || (k == 2)) ^ inv;   // R7
         ta = !ena ? "R8" : ((ilv && k >= 2) ? "R6" : $sformatf("R%0d", tg));
         tb = ilv ? "R6" : (!enb ? "R8" : "R5");
         chk(ta, out_a, !ena ? '0 : ((ilv && k >= 2) ? hb : ha));
         chk(tb, out_b, enb ? hb : '0);
         chk("R7", dco_a, ena & dv);
         chk("R7", dco_b, enb & dv);
         chk("R8", drv_a_en, ena);
         chk("R8", drv_b_en, enb);
         @(negedge clk);
      end
      p++;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R1: reset state
      chk("R1", out_a, 0);
      chk("R1", out_b, 0);
      chk("R1", dco_a, 0);
      chk("R1", dco_b, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R7: every 14-bit code in separate-bus mode
      for (int v = 0; v < 16384; v++)
         period(DW'(v), DW'(v * 37 + 5), 2'(v % 4), 1'b0, 1'((v / 1024) % 2),
                1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R6 R8: interleaved bus with enables and power-down
      for (int v = 0; v < 400; v++)
         period(DW'(v * 411 + 9), DW'(v * 1297 + 3001), 2'(v % 3), 1'b1, 1'(v % 2),
                1'b0, 1'b0, 1'(v % 7 == 3), 1'(v % 5 == 1), 1'(v % 11 == 5));

      // R9 R10: pseudorandom words with holds and pauses
      for (int v = 0; v < 300; v++)
         period(DW'(v), DW'(~v), 2'(v % 3), 1'(v % 4 == 2), 1'b0,
                1'(v % 50 != 49), 1'(v < 5 || (v >= 100 && v < 104)),
                1'b0, 1'b0, 1'b0);

      // R5 R8: separate buses with channel-level disables
      for (int v = 0; v < 40; v++)
         period(DW'(v * 3), DW'(v * 5 + 1), 2'd0, 1'b0, 1'(v % 3 == 0),
                1'b0, 1'b0, 1'(v % 2), 1'(v % 3 == 1), 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule